// File: doc/BRIEF.md
# Multi-Level Sequential Trigger Engine

This block decides when a logic analyzer starts acquiring data. A 32-channel input bus is sampled on every rising clock edge and compared against four pattern recognizers. Each recognizer holds a value word and a care-mask word, so every channel can be set to demand a 1, demand a 0, or be ignored. A recognizer raises its hit flag when all of the channels it cares about agree with its value word.

A sequencer walks through a program of up to sixteen levels. Each level names the one recognizer it is waiting for. While the engine hunts, a hit from that recognizer moves it to the next level, and hits from every other recognizer are ignored. The sequence ends at the first level that carries a final flag, or at level 15 if no level carries one. A hit at that level raises the trigger, which then stays high until the engine is armed again or reset.

Software loads patterns and the level program through a simple write port while the engine is idle. It then pulses arm and watches the trigger, busy and current-level outputs.

Top module: `seqtrig_top`

## Requirements
- R1: After reset `trigOut` and `busyOut` are 0 and `levelOut` is 0.
- R2: Recognizer k hits on a sample s exactly when ((s XOR value_k) AND mask_k) is zero. A mask bit of 1 demands the value bit and a mask bit of 0 makes the channel don't-care.
- R3: A write with `cfgWe` high takes effect on the rising edge. Address 2k (k = 0..3) loads value_k, and address 2k+1 loads mask_k. Address 16+L loads level L: `cfgData[1:0]` selects the recognizer and `cfgData[2]` is the final flag. After reset every value, mask, select and flag is 0.
- R4: While busy, a sample on which the recognizer selected by the current level hits, at a level that is not final, increments `levelOut` by exactly one on that edge. Hits from other recognizers leave the level unchanged. At most one level is advanced per sample.
- R5: A level is final when its final flag is 1 or its index is 15. A hit of its selected recognizer while busy sets `trigOut` and clears `busyOut` on that edge, and `levelOut` keeps the final index.
- R6: Once set, `trigOut` stays 1, and `levelOut` stays unchanged, regardless of later samples, until `armIn` or reset.
- R7: An edge with `armIn` high sets `levelOut` to 0, clears `trigOut` and sets `busyOut`, even if a hit occurs on the same sample.
- R8: `busyOut` is high exactly while the engine is armed and has not yet triggered, and it is never high together with `trigOut`. When not busy, samples do not change `levelOut`.
- R9: Writes arriving while `busyOut` is high are ignored. The old patterns and level program stay in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleIn | input | 32 | Sampled input channels |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 5 | Configuration address (see R3) |
| cfgData | input | 32 | Configuration write data |
| armIn | input | 1 | Arm / re-arm pulse |
| trigOut | output | 1 | Trigger, held until re-arm or reset |
| busyOut | output | 1 | Armed and not yet triggered |
| levelOut | output | 4 | Current sequence level index |

## Verification
The assertions assume that every input is stable across each rising edge. They also assume that `armIn` is a level qualified per sample rather than an asynchronous event, and that the configuration address stays within the map of R3 while `cfgWe` is high. The bench changes all inputs one time unit after an edge and holds them until the next edge. It draws addresses only from the decoded ranges. Arm, write and sample patterns are chosen so that re-arming, writing while busy and same-sample multi-recognizer hits all occur inside that envelope.

// File: rtl/seqtrig_pkg.sv
package seqtrig_pkg;

  localparam int DEF_CHAN_W  = 32;
  localparam int DEF_NUM_REC = 4;
  localparam int DEF_NUM_LVL = 16;

  // Strobes issued by the control FSM to the sequence datapath.
  typedef struct packed {
    logic clrSeq;   // restart: level to 0, trigger cleared
    logic stepLvl;  // advance one level
    logic setTrig;  // final level satisfied
  } seqStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_DONE = 2'd2
  } seqState_t;

endpackage

// File: rtl/seqtrig_datapath.sv
module seqtrig_datapath
  import seqtrig_pkg::*;
#(
  parameter int ChanW  = DEF_CHAN_W,
  parameter int NumRec = DEF_NUM_REC,
  parameter int NumLvl = DEF_NUM_LVL
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ChanW-1:0]           sampleIn,
  input  logic                       cfgWe,
  input  logic [$clog2(NumLvl):0]    cfgAddr,
  input  logic [ChanW-1:0]           cfgData,
  input  logic                       busyIn,
  input  seqStrobe_t                 strb,
  output logic                       lvlHit,
  output logic                       lvlFinal,
  output logic [$clog2(NumLvl)-1:0]  levelOut,
  output logic                       trigOut
);

  localparam int RecW  = $clog2(NumRec);
  localparam int LvlW  = $clog2(NumLvl);
  localparam int AddrW = LvlW + 1;
  localparam int SlotW = LvlW - 1;

  logic [NumRec-1:0][ChanW-1:0] patValQ;
  logic [NumRec-1:0][ChanW-1:0] patMaskQ;
  logic [NumLvl-1:0][RecW-1:0]  lvlSelQ;
  logic [NumLvl-1:0]            lvlLastQ;
  logic [NumRec-1:0]            recHit;
  logic [LvlW-1:0]              levelQ;
  logic                         trigQ;

  logic cfgOpen;
  logic lvlSpace;
  assign cfgOpen  = cfgWe && !busyIn;
  assign lvlSpace = cfgAddr[AddrW-1];

  // Pattern storage: even slot = value, odd slot = care mask.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      patValQ  <= '0;
      patMaskQ <= '0;
    end else if (cfgOpen && !lvlSpace) begin
      for (int k = 0; k < NumRec; k++) begin
        if (cfgAddr[LvlW-1:1] == SlotW'(k)) begin
          if (cfgAddr[0]) patMaskQ[k] <= cfgData;
          else            patValQ[k]  <= cfgData;
        end
      end
    end
  end

  // Level program: recognizer select plus final flag.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvlSelQ  <= '0;
      lvlLastQ <= '0;
    end else if (cfgOpen && lvlSpace) begin
      for (int l = 0; l < NumLvl; l++) begin
        if (cfgAddr[LvlW-1:0] == LvlW'(l)) begin
          lvlSelQ[l]  <= cfgData[RecW-1:0];
          lvlLastQ[l] <= cfgData[RecW];
        end
      end
    end
  end

  // Three-valued comparators, one per recognizer.
  generate
    for (genvar k = 0; k < NumRec; k++) begin : gRec
      assign recHit[k] = ((sampleIn ^ patValQ[k]) & patMaskQ[k]) == '0;
    end
  endgenerate

  assign lvlHit   = recHit[lvlSelQ[levelQ]];
  assign lvlFinal = lvlLastQ[levelQ] || (levelQ == LvlW'(NumLvl - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ <= '0;
      trigQ  <= 1'b0;
    end else if (strb.clrSeq) begin
      levelQ <= '0;
      trigQ  <= 1'b0;
    end else begin
      if (strb.stepLvl) levelQ <= levelQ + 1'b1;
      if (strb.setTrig) trigQ  <= 1'b1;
    end
  end

  assign levelOut = levelQ;
  assign trigOut  = trigQ;

  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (levelQ == $past(levelQ)) || (levelQ == $past(levelQ) + 1'b1) || (levelQ == '0)); // R4
  AST_TRIG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    trigQ && !strb.clrSeq |=> trigQ && $stable(levelQ)); // R6
  AST_ARM_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrSeq |=> (levelQ == '0) && !trigQ); // R7
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    busyIn |=> $stable(lvlSelQ) && $stable(lvlLastQ) && $stable(patValQ) && $stable(patMaskQ)); // R9
  AST_FINAL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    strb.setTrig |=> trigQ && $stable(levelQ)); // R5

endmodule

// File: rtl/seqtrig_control.sv
module seqtrig_control
  import seqtrig_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       armIn,
  input  logic       lvlHit,
  input  logic       lvlFinal,
  output seqStrobe_t strb,
  output logic       busyOut
);

  seqState_t stateQ, stateD;
  logic      hunting;

  assign hunting = (stateQ == ST_HUNT) && !armIn;

  always_comb begin
    strb         = '0;
    strb.clrSeq  = armIn;
    strb.stepLvl = hunting && lvlHit && !lvlFinal;
    strb.setTrig = hunting && lvlHit && lvlFinal;
  end

  always_comb begin
    stateD = stateQ;
    if (armIn)             stateD = ST_HUNT;
    else if (strb.setTrig) stateD = ST_DONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign busyOut = (stateQ == ST_HUNT);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb)); // R4
  AST_ARM_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    armIn |=> busyOut); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busyOut |-> !strb.stepLvl && !strb.setTrig); // R8

endmodule

// File: rtl/seqtrig_top.sv
module seqtrig_top
  import seqtrig_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] sampleIn,
  input  logic        cfgWe,
  input  logic [4:0]  cfgAddr,
  input  logic [31:0] cfgData,
  input  logic        armIn,
  output logic        trigOut,
  output logic        busyOut,
  output logic [3:0]  levelOut
);

  localparam int ChanW  = DEF_CHAN_W;
  localparam int NumRec = DEF_NUM_REC;
  localparam int NumLvl = DEF_NUM_LVL;

  seqStrobe_t strb;
  logic       lvlHit;
  logic       lvlFinal;

  seqtrig_control uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .armIn    (armIn),
    .lvlHit   (lvlHit),
    .lvlFinal (lvlFinal),
    .strb     (strb),
    .busyOut  (busyOut)
  );

  seqtrig_datapath #(
    .ChanW  (ChanW),
    .NumRec (NumRec),
    .NumLvl (NumLvl)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .sampleIn (sampleIn),
    .cfgWe    (cfgWe),
    .cfgAddr  (cfgAddr),
    .cfgData  (cfgData),
    .busyIn   (busyOut),
    .strb     (strb),
    .lvlHit   (lvlHit),
    .lvlFinal (lvlFinal),
    .levelOut (levelOut),
    .trigOut  (trigOut)
  );

  AST_BUSY_TRIG_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(busyOut && trigOut)); // R8
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !busyOut && !trigOut); // R1

endmodule

// File: tb/tb_seqtrig_top.sv
module tb_seqtrig_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] sampleIn = '0;
  logic        cfgWe = 1'b0;
  logic [4:0]  cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic        armIn = 1'b0;
  logic        trigOut;
  logic        busyOut;
  logic [3:0]  levelOut;

  int vectors = 0;
  int miscompares = 0;

  // Bench model state
  logic [31:0] mVal [4];
  logic [31:0] mMask [4];
  logic [1:0]  mSel [16];
  logic        mLast [16];
  int          mLevel;
  logic        mTrig;
  logic        mBusy;

  seqtrig_top dut (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .cfgWe(cfgWe),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .armIn(armIn),
    .trigOut(trigOut), .busyOut(busyOut), .levelOut(levelOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic mHit(input int k, input logic [31:0] s);
    return ((s ^ mVal[k]) & mMask[k]) == 32'd0;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // One sample period: drive, clock, update model, compare.
  task automatic cyc(input logic [31:0] s, input logic arm, input logic we,
                     input logic [4:0] a, input logic [31:0] d, input string tag);
    logic preBusy;
    sampleIn = s; armIn = arm; cfgWe = we; cfgAddr = a; cfgData = d;
    @(posedge clk);
    preBusy = mBusy;
    if (arm) begin
      mLevel = 0; mTrig = 1'b0; mBusy = 1'b1;
    end else if (mBusy && mHit(int'(mSel[mLevel]), s)) begin
      if (mLast[mLevel] || mLevel == 15) begin
        mTrig = 1'b1; mBusy = 1'b0;
      end else begin
        mLevel = mLevel + 1;
      end
    end
    if (we && !preBusy) begin
      if (a[4]) begin
        mSel[a[3:0]] = d[1:0];
        mLast[a[3:0]] = d[2];
      end else if (a[0]) mMask[a[2:1]] = d;
      else               mVal[a[2:1]] = d;
    end
    #1;
    chk(tag, "level", int'(levelOut), mLevel);
    chk(tag, "trig", int'(trigOut), int'(mTrig));
    chk(tag, "busy", int'(busyOut), int'(mBusy));
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input string tag);
    cyc(32'hFFFF_FFFF, 1'b0, 1'b1, a, d, tag);
  endtask

  task automatic smp(input logic [31:0] s, input string tag);
    cyc(s, 1'b0, 1'b0, 5'd0, 32'd0, tag);
  endtask

  task automatic arm(input logic [31:0] s, input string tag);
    cyc(s, 1'b1, 1'b0, 5'd0, 32'd0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    for (int k = 0; k < 4; k++) begin mVal[k] = '0; mMask[k] = '0; end
    for (int l = 0; l < 16; l++) begin mSel[l] = '0; mLast[l] = 1'b0; end
    mLevel = 0; mTrig = 1'b0; mBusy = 1'b0;

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    chk("R1", "level", int'(levelOut), 0);
    chk("R1", "trig", int'(trigOut), 0);
    chk("R1", "busy", int'(busyOut), 0);

    // Idle engine: all-don't-care recognizers hit, yet nothing moves.
    smp(32'h0, "R8");
    smp(32'hDEAD_BEEF, "R8");

    // Load patterns and a four-level program.
    wr(5'd0, 32'h0000_00A5, "R3"); wr(5'd1, 32'h0000_00FF, "R3");
    wr(5'd2, 32'hF000_0000, "R3"); wr(5'd3, 32'hF000_0000, "R3");
    wr(5'd4, 32'h0000_0000, "R3"); wr(5'd5, 32'h0000_FFFF, "R3");
    wr(5'd6, 32'h1234_5678, "R3"); wr(5'd7, 32'hFFFF_FFFF, "R3");
    wr(5'd16, 32'd1, "R3"); wr(5'd17, 32'd0, "R3");
    wr(5'd18, 32'd3, "R3"); wr(5'd19, 32'd4, "R3");

    arm(32'h0, "R7");
    smp(32'h0000_00A5, "R4");      // only recognizer 0: ignored at level 0
    smp(32'hF000_00A5, "R4");      // 0 and 1 hit: exactly one step
    wr(5'd17, 32'd3, "R9");        // ignored while busy
    smp(32'h0000_00A5, "R9");      // level 1 still waits on recognizer 0
    smp(32'h1234_5678, "R4");
    smp(32'h0000_00A5, "R5");      // final level fires
    smp(32'h0000_00A5, "R6");
    smp(32'h1234_5678, "R6");
    arm(32'hF000_00A5, "R7");      // arm wins over a same-sample hit
    smp(32'hF000_00A5, "R4");
    smp(32'h0000_00A5, "R4");
    smp(32'h1234_5678, "R4");
    smp(32'h0000_00A5, "R5");

    // Sixteen levels with no final flag: implicit end at level 15.
    for (int l = 0; l < 16; l++) wr(5'(16 + l), 32'd2, "R3");
    arm(32'h0, "R7");
    for (int l = 0; l < 16; l++) smp(32'h0001_0000, "R5");
    smp(32'h0001_0000, "R6");

    // Per-bit sweep over recognizer 3 with a one-level program.
    wr(5'd16, 32'd7, "R3");
    for (int b = 0; b < 32; b++) begin
      wr(5'd7, ~(32'd1 << b), "R2");
      arm(32'h0, "R2");
      smp(32'h1234_5678 ^ (32'd1 << b), "R2");   // flipped bit is don't-care
      wr(5'd7, 32'hFFFF_FFFF, "R2");
      arm(32'h0, "R2");
      smp(32'h1234_5678 ^ (32'd1 << b), "R2");   // now it must miss
      smp(32'h1234_5678, "R2");
    end

    // Mixed sweep: arms, writes and pattern-rich samples.
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] s;
      logic [4:0]  a;
      int          pick;
      pick = int'($urandom_range(0, 5));
      case (pick)
        0: s = 32'h0000_00A5;
        1: s = 32'hF000_00A5;
        2: s = 32'h1234_5678;
        3: s = 32'h0001_0000;
        4: s = 32'hF000_0000;
        default: s = $urandom;
      endcase
      a = ($urandom_range(0, 1) == 0) ? 5'($urandom_range(0, 7)) : 5'($urandom_range(16, 31));
      cyc(s, ($urandom_range(0, 15) == 0), ($urandom_range(0, 7) == 0), a,
          (a[4] ? 32'($urandom_range(0, 7)) : (($urandom_range(0, 1) == 0) ? 32'hFFFF_0000 : s)),
          "R4");
    end

    finishRun();
  end

endmodule